// File: doc/BRIEF.md
# CPU and USB Clock Divider Unit

This block derives two slower clocks from one fast PLL clock. The CPU side is an 8-bit programmable divider. It produces a one-cycle clock-enable pulse once per divided period. The USB side is a half-period counter that drives a toggle stage, so its output always has a 50% duty cycle and an even overall ratio. When a dedicated USB PLL reports that it is connected, the USB output is taken straight from that PLL's clock and the USB divider setting has no effect on the output.

Software sets both divide values through a small register interface. It has a write strobe with a one-bit register address, and a combinational read port. While the main PLL is connected, the CPU field refuses the two fastest ratios, divide-by-1 and divide-by-2. A refused write leaves the field unchanged and raises a sticky error flag. A newly written ratio on either path waits for the end of the period already in progress. As a result, no output period is ever cut short.

Top module: `clk_div_unit`

## Requirements
- R1: With CPU field value s (register address 0, bits [7:0]), `cpu_clk_en` is high for exactly one cycle in every s+1 cycles, so ratios run from 1 to 256.
- R2: After reset, both fields read zero and `cfg_err` is low. With the CPU field at zero, `cpu_clk_en` is high on every cycle, and the USB output toggles on every cycle.
- R3: A CPU field write does not disturb the period in progress. The new ratio applies from the next `cpu_clk_en` pulse onward.
- R4: While `main_pll_conn` is high, a write of 0 or 1 to the CPU field is discarded and the field keeps its value. Writes of 2 or more are accepted. While `main_pll_conn` is low, every value is accepted.
- R5: `cfg_err` goes high on a discarded CPU write and stays high until reset.
- R6: With `usb_pll_conn` low and USB field value u (register address 1, bits [3:0]), `usb_clk` stays high for u+1 cycles and then low for u+1 cycles. The overall ratio is 2*(u+1).
- R7: A USB field write does not disturb the half period in progress. The new value applies from the next toggle onward.
- R8: While `usb_pll_conn` is high, `usb_clk` equals `usb_pll_clk`, whatever the USB field holds.
- R9: Bits above each field read back as zero, and ones written to them are discarded.
- R10: `rd_data` shows the register selected by `rd_addr` in the same cycle: 0 selects the CPU field and 1 selects the USB field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pll_clk | input | 1 | Fast main PLL clock; clocks all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_pll_conn | input | 1 | Main PLL connected status |
| usb_pll_conn | input | 1 | Dedicated USB PLL connected status |
| usb_pll_clk | input | 1 | Dedicated USB PLL clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 CPU field, 1 USB field |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address: 0 CPU field, 1 USB field |
| rd_data | output | 32 | Read data, zero-extended field |
| cpu_clk_en | output | 1 | CPU divided clock enable pulse |
| usb_clk | output | 1 | USB clock, divided or bypassed |
| cfg_err | output | 1 | Sticky flag for a refused CPU write |

## Verification
The bench sweeps all 16 USB values and a wide range of CPU values, including 0, 1, 254 and 255. A counter with an off-by-one reload or a misplaced toggle would produce periods one cycle long or short. The bench also writes a new ratio part-way through a long period. A design that reloaded on write would shorten that period, and a design that ignored the pending value for an extra period would show it on the second measurement. Writes of 0 and 1 are issued with the main PLL both connected and disconnected. A design that checked the wrong condition would either lock up the fast ratios or accept a forbidden one, and a non-sticky flag would drop after a later legal write. Upper data bits are written as ones to catch readback leakage.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;

    localparam int CPU_SEL_W_DEF = 8;
    localparam int USB_SEL_W_DEF = 4;
    localparam int BUS_W_DEF     = 32;

    typedef enum logic {
        REG_CPU = 1'b0,
        REG_USB = 1'b1
    } reg_addr_e;

endpackage

// File: rtl/clk_div_regs.sv
module clk_div_regs
    import clk_div_pkg::*;
#(
    parameter int CPU_W = CPU_SEL_W_DEF,
    parameter int USB_W = USB_SEL_W_DEF,
    parameter int BUS_W = BUS_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_pll_conn,
    input  logic              wr_en,
    input  reg_addr_e         wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  reg_addr_e         rd_addr,
    output logic [BUS_W-1:0]  rd_data,
    output logic [CPU_W-1:0]  cpu_sel,
    output logic [USB_W-1:0]  usb_sel,
    output logic              cfg_err
);

    localparam logic [CPU_W-1:0] LOCK_MIN = CPU_W'(2);

    typedef struct packed {
        logic [CPU_W-1:0] cpu;
        logic [USB_W-1:0] usb;
        logic             err;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  too_fast;

    always_comb begin
        regs_d   = regs_q;
        too_fast = main_pll_conn && (wr_data[CPU_W-1:0] < LOCK_MIN);
        if (wr_en) begin
            case (wr_addr)
                REG_CPU: begin
                    if (too_fast) regs_d.err = 1'b1;
                    else          regs_d.cpu = wr_data[CPU_W-1:0];
                end
                REG_USB: regs_d.usb = wr_data[USB_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_CPU: rd_data[CPU_W-1:0] = regs_q.cpu;
            REG_USB: rd_data[USB_W-1:0] = regs_q.usb;
            default: ;
        endcase
    end

    assign cpu_sel = regs_q.cpu;
    assign usb_sel = regs_q.usb;
    assign cfg_err = regs_q.err;

endmodule

// File: rtl/clk_div_cpu.sv
module clk_div_cpu
    import clk_div_pkg::*;
#(
    parameter int SEL_W = CPU_SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_en,
    output logic [SEL_W-1:0] cnt
);

    typedef struct packed {
        logic [SEL_W-1:0] cnt;
    } cpu_st_t;

    cpu_st_t st_d, st_q;
    logic    at_term;

    always_comb begin
        st_d    = st_q;
        at_term = (st_q.cnt == '0);
        if (at_term) st_d.cnt = sel;
        else         st_d.cnt = st_q.cnt - SEL_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_en = at_term;
    assign cnt     = st_q.cnt;

endmodule

// File: rtl/clk_div_usb.sv
module clk_div_usb
    import clk_div_pkg::*;
#(
    parameter int SEL_W = USB_SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_conn,
    input  logic             ext_clk,
    output logic             clk_out,
    output logic [SEL_W-1:0] cnt,
    output logic             phase
);

    typedef struct packed {
        logic [SEL_W-1:0] cnt;
        logic             phase;
    } usb_st_t;

    usb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            st_d.cnt   = sel;
            st_d.phase = ~st_q.phase;
        end else begin
            st_d.cnt   = st_q.cnt - SEL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_out = ext_conn ? ext_clk : st_q.phase;
    assign cnt     = st_q.cnt;
    assign phase   = st_q.phase;

endmodule

// File: rtl/clk_div_unit.sv
module clk_div_unit #(
    parameter int CPU_SEL_W = 8,
    parameter int USB_SEL_W = 4,
    parameter int BUS_W     = 32
) (
    input  logic             pll_clk,
    input  logic             rst_n,
    input  logic             main_pll_conn,
    input  logic             usb_pll_conn,
    input  logic             usb_pll_clk,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [BUS_W-1:0] rd_data,
    output logic             cpu_clk_en,
    output logic             usb_clk,
    output logic             cfg_err
);

    logic [CPU_SEL_W-1:0] cpu_sel;
    logic [USB_SEL_W-1:0] usb_sel;
    logic [CPU_SEL_W-1:0] cpu_cnt;
    logic [USB_SEL_W-1:0] usb_cnt;
    logic                 usb_phase;

    clk_div_regs #(
        .CPU_W (CPU_SEL_W),
        .USB_W (USB_SEL_W),
        .BUS_W (BUS_W)
    ) u_regs (
        .clk           (pll_clk),
        .rst_n         (rst_n),
        .main_pll_conn (main_pll_conn),
        .wr_en         (wr_en),
        .wr_addr       (clk_div_pkg::reg_addr_e'(wr_addr)),
        .wr_data       (wr_data),
        .rd_addr       (clk_div_pkg::reg_addr_e'(rd_addr)),
        .rd_data       (rd_data),
        .cpu_sel       (cpu_sel),
        .usb_sel       (usb_sel),
        .cfg_err       (cfg_err)
    );

    clk_div_cpu #(
        .SEL_W (CPU_SEL_W)
    ) u_cpu (
        .clk     (pll_clk),
        .rst_n   (rst_n),
        .sel     (cpu_sel),
        .tick_en (cpu_clk_en),
        .cnt     (cpu_cnt)
    );

    clk_div_usb #(
        .SEL_W (USB_SEL_W)
    ) u_usb (
        .clk      (pll_clk),
        .rst_n    (rst_n),
        .sel      (usb_sel),
        .ext_conn (usb_pll_conn),
        .ext_clk  (usb_pll_clk),
        .clk_out  (usb_clk),
        .cnt      (usb_cnt),
        .phase    (usb_phase)
    );

endmodule

// File: rtl/clk_div_unit_chk.sv
module clk_div_unit_chk #(
    parameter int CPU_W = 8,
    parameter int USB_W = 4,
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             main_pll_conn,
    input logic             wr_en,
    input logic             wr_addr,
    input logic [CPU_W-1:0] wr_low,
    input logic [CPU_W-1:0] cpu_sel,
    input logic [CPU_W-1:0] cpu_cnt,
    input logic             cpu_clk_en,
    input logic [USB_W-1:0] usb_cnt,
    input logic             usb_phase,
    input logic [BUS_W-1:0] rd_data,
    input logic             cfg_err
);

    localparam logic [CPU_W-1:0] LOCK_MIN = CPU_W'(2);

    AST_CPU_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |=> (cpu_cnt == $past(cpu_sel)));  // R1

    AST_CPU_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |=> (cpu_cnt == $past(cpu_cnt) - CPU_W'(1)));  // R3

    AST_FAST_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (main_pll_conn && wr_en && !wr_addr && (wr_low < LOCK_MIN))
        |=> ($stable(cpu_sel) && cfg_err));  // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);  // R5

    AST_USB_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_cnt == '0) |=> (usb_phase != $past(usb_phase)));  // R6

    AST_USB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_cnt != '0) |=> $stable(usb_phase));  // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BUS_W-1:CPU_W] == '0);  // R9

endmodule

bind clk_div_unit clk_div_unit_chk #(
    .CPU_W (CPU_SEL_W),
    .USB_W (USB_SEL_W),
    .BUS_W (BUS_W)
) u_chk (
    .clk           (pll_clk),
    .rst_n         (rst_n),
    .main_pll_conn (main_pll_conn),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_low        (wr_data[CPU_SEL_W-1:0]),
    .cpu_sel       (cpu_sel),
    .cpu_cnt       (cpu_cnt),
    .cpu_clk_en    (cpu_clk_en),
    .usb_cnt       (usb_cnt),
    .usb_phase     (usb_phase),
    .rd_data       (rd_data),
    .cfg_err       (cfg_err)
);

// File: tb/clk_div_unit_test.sv
module clk_div_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        main_pll_conn = 1'b0;
    logic        usb_pll_conn = 1'b0;
    logic        usb_pll_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic        cpu_clk_en;
    logic        usb_clk;
    logic        cfg_err;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_div_unit uut (
        .pll_clk       (clk),
        .rst_n         (rst_n),
        .main_pll_conn (main_pll_conn),
        .usb_pll_conn  (usb_pll_conn),
        .usb_pll_clk   (usb_pll_clk),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .cpu_clk_en    (cpu_clk_en),
        .usb_clk       (usb_clk),
        .cfg_err       (cfg_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input bit a, input logic [31:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic rd(input bit a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_en();
        tick();
        while (!cpu_clk_en) tick();
    endtask

    task automatic cpu_period(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!cpu_clk_en);
    endtask

    task automatic usb_sync();
        logic v;
        v = usb_clk;
        while (usb_clk == v) tick();
    endtask

    task automatic usb_run(output int n);
        logic v;
        v = usb_clk;
        n = 0;
        while (usb_clk == v) begin
            tick();
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n, m, k;
        logic prev;
        int big_vals [3] = '{100, 254, 255};

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R2: reset state
        rd(1'b0, v); check(v == 0, "R2 cpu field reset", v, 0);
        rd(1'b1, v); check(v == 0, "R2 usb field reset", v, 0);
        check(cfg_err == 1'b0, "R2 err reset", cfg_err, 0);
        prev = usb_clk;
        for (int i = 0; i < 4; i++) begin
            tick();
            check(cpu_clk_en == 1'b1, "R2 divide-by-1 enable", cpu_clk_en, 1);
            check(usb_clk != prev, "R2 usb toggles each cycle", usb_clk, !prev);
            prev = usb_clk;
        end

        // R9 / R10: reserved bits and read select
        wr(1'b0, 32'hFFFF_FF07);
        rd(1'b0, v); check(v == 32'h7, "R9 cpu reserved bits", v, 7);
        wr(1'b1, 32'hFFFF_FFF3);
        rd(1'b1, v); check(v == 32'h3, "R9 usb reserved bits", v, 3);
        rd(1'b0, v); check(v == 32'h7, "R10 cpu read after usb write", v, 7);

        // R4 / R5: refused fast ratios while main PLL connected
        wr(1'b0, 32'd5);
        main_pll_conn = 1'b1;
        check(cfg_err == 1'b0, "R5 err low before refusal", cfg_err, 0);
        wr(1'b0, 32'd1);
        rd(1'b0, v); check(v == 5, "R4 write of 1 refused", v, 5);
        check(cfg_err == 1'b1, "R5 err set", cfg_err, 1);
        wr(1'b0, 32'd0);
        rd(1'b0, v); check(v == 5, "R4 write of 0 refused", v, 5);
        wr(1'b0, 32'd2);
        rd(1'b0, v); check(v == 2, "R4 write of 2 accepted", v, 2);
        main_pll_conn = 1'b0;
        wr(1'b0, 32'd0);
        rd(1'b0, v); check(v == 0, "R4 write of 0 accepted when disconnected", v, 0);
        check(cfg_err == 1'b1, "R5 err sticky", cfg_err, 1);
        wr(1'b0, 32'd1);
        rd(1'b0, v); check(v == 1, "R4 write of 1 accepted when disconnected", v, 1);
        check(cfg_err == 1'b1, "R5 err still sticky", cfg_err, 1);

        // R1: CPU ratio sweep
        for (int s = 0; s < 28; s++) begin
            wr(1'b0, 32'(s));
            wait_en(); wait_en();
            cpu_period(n);
            cpu_period(m);
            check(n == s + 1, "R1 cpu period", n, s + 1);
            check(m == s + 1, "R1 cpu period repeat", m, s + 1);
        end
        foreach (big_vals[j]) begin
            wr(1'b0, 32'(big_vals[j]));
            wait_en(); wait_en();
            cpu_period(n);
            check(n == big_vals[j] + 1, "R1 cpu period large", n, big_vals[j] + 1);
        end

        // R3: mid-period write
        wr(1'b0, 32'd9);
        wait_en(); wait_en();
        k = 0;
        wr(1'b0, 32'd2);
        k = 1;
        while (!cpu_clk_en) begin
            tick();
            k++;
        end
        check(k == 10, "R3 old period completes", k, 10);
        cpu_period(n);
        check(n == 3, "R3 new period applies", n, 3);

        // R6: USB exhaustive sweep
        for (int u = 0; u < 16; u++) begin
            wr(1'b1, 32'(u));
            usb_sync(); usb_sync();
            usb_run(n);
            usb_run(m);
            check(n == u + 1, "R6 usb half period", n, u + 1);
            check(m == u + 1, "R6 usb other half period", m, u + 1);
        end

        // R7: mid-half-period write
        wr(1'b1, 32'd15);
        usb_sync(); usb_sync();
        prev = usb_clk;
        wr(1'b1, 32'd0);
        k = 1;
        while (usb_clk == prev) begin
            tick();
            k++;
        end
        check(k == 16, "R7 old half period completes", k, 16);
        usb_run(n);
        check(n == 1, "R7 new half period applies", n, 1);

        // R8: bypass
        usb_pll_conn = 1'b1;
        wr(1'b1, 32'd7);
        for (int i = 0; i < 8; i++) begin
            usb_pll_clk = ((i * 5) >> 1) & 1;
            #1;
            check(usb_clk == usb_pll_clk, "R8 bypass follows pll", usb_clk, usb_pll_clk);
            tick();
        end
        usb_pll_clk = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick();
            check(usb_clk == 1'b1, "R8 divider setting ignored", usb_clk, 1);
        end
        usb_pll_conn = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule